// File: doc/BRIEF.md
# Eight-Lane 52-Bit Multiply-Accumulate Unit

This block is a SIMD integer multiply-accumulate datapath for multi-word arithmetic that stores big numbers as 52-bit digits in 64-bit containers. Each operation carries three 512-bit vectors: an accumulator and two multiplicands. All three are cut into eight independent 64-bit lanes. In every lane, the low 52 bits of the two multiplicand lanes are multiplied into a 104-bit unsigned product.

A single half-select input picks either the lower or the upper 52 bits of each product. The selected half is widened with zeros and added to the full 64-bit accumulator lane. The spare top 12 bits of each lane can therefore gather carries over many accumulations before software normalises the digits.

Operations enter through a valid/ready input handshake and leave through a valid/ready output handshake. With the output draining freely, the unit has a fixed two-cycle latency: the products are registered first, and the lane sums are registered second.

Top module: `mac52_simd`

## Requirements
- R1: Lane j occupies bits 64j+63:64j of every vector. Each lane is computed independently, and a lane sum that wraps passes no carry into lane j+1.
- R2: Bits 63:52 of every multiplicand lane have no effect on the result. Only bits 51:0 are multiplied.
- R3: With half_i = 0 (lower half), each result lane equals the accumulator lane plus product bits 51:0 of the two zero-extended 52-bit multiplicands.
- R4: With half_i = 1 (upper half), each result lane equals the accumulator lane plus product bits 103:52.
- R5: The 64-bit lane addition wraps modulo 2^64.
- R6: An operation accepted in cycle k, with out_ready_i high from then on, appears on out_valid_o/out_data_o in cycle k+2. Results leave in acceptance order.
- R7: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o stays unchanged in the next cycle.
- R8: in_ready_o is low exactly when out_valid_o is high and out_ready_i is low.
- R9: During reset and right after it, out_valid_o is 0 and in_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | An operation is offered |
| in_ready_o | output | 1 | The unit takes the offered operation at this edge |
| half_i | input | 1 | Product half select: 0 lower 52 bits, 1 upper 52 bits |
| acc_i | input | 512 | Accumulator vector, eight 64-bit lanes |
| mul_a_i | input | 512 | First multiplicand vector, bits 51:0 of each lane used |
| mul_b_i | input | 512 | Second multiplicand vector, bits 51:0 of each lane used |
| out_valid_o | output | 1 | A result is held on out_data_o |
| out_ready_i | input | 1 | The consumer takes the result at this edge |
| out_data_o | output | 512 | Result vector, eight 64-bit lanes |

## Verification
All-ones 52-bit multiplicands over an all-ones accumulator give a lower half of exactly 1, so every lane must wrap to zero. The same multiplicands in upper-half mode separate bits 103:52 from any off-by-one slice. Alternating wrapping and zero lanes expose a carry that leaks into the next lane, and multiplicands with garbage in bits 63:52 show whether the unused bits are masked. Random vectors, lanes forced to all ones, and accumulators close to 2^64, under free-flowing, random and heavily stalled output readiness, separate ordering, latency and hold faults from arithmetic faults.

// File: rtl/mac52_pkg.sv
package mac52_pkg;
  localparam int unsigned LANES_D  = 8;
  localparam int unsigned LANE_W_D = 64;
  localparam int unsigned MUL_W_D  = 52;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/mac52_lane.sv
module mac52_lane #(
  parameter int unsigned LANE_W = 64,
  parameter int unsigned MUL_W  = 52
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              half_i,
  input  logic [LANE_W-1:0] acc_i,
  input  logic [LANE_W-1:0] mul_a_i,
  input  logic [LANE_W-1:0] mul_b_i,
  output logic [LANE_W-1:0] res_o
);
  import mac52_pkg::*;

  localparam int unsigned PROD_W = 2 * MUL_W;
  localparam int unsigned PAD_W  = LANE_W - MUL_W;

  logic [PROD_W-1:0] op_a, op_b, prod_d, prod_q;
  logic [LANE_W-1:0] acc_q, addend, sum;
  logic [MUL_W-1:0]  pick;
  half_e             half_q;

  // upper container bits are dropped before the multiplier
  assign op_a   = {{MUL_W{1'b0}}, mul_a_i[MUL_W-1:0]};
  assign op_b   = {{MUL_W{1'b0}}, mul_b_i[MUL_W-1:0]};
  assign prod_d = op_a * op_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      acc_q  <= '0;
      half_q <= HALF_LO;
    end else if (load_i) begin
      prod_q <= prod_d;
      acc_q  <= acc_i;
      half_q <= half_e'(half_i);
    end
  end

  always_comb begin
    if (half_q == HALF_HI) pick = prod_q[PROD_W-1:MUL_W];
    else                   pick = prod_q[MUL_W-1:0];
  end

  assign addend = {{PAD_W{1'b0}}, pick};
  assign sum    = acc_q + addend;  // modulo 2^LANE_W, no lane carry out

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    res_o <= '0;
    else if (adv_i) res_o <= sum;
  end
endmodule

// File: rtl/mac52_pipe_ctrl.sv
module mac52_pipe_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  output logic in_ready_o,
  output logic out_valid_o,
  input  logic out_ready_i,
  output logic load_o,
  output logic adv_o
);
  logic prod_full_q, res_full_q;

  // take new work only if the result slot is empty or leaving
  assign in_ready_o  = !res_full_q || out_ready_i;
  assign load_o      = in_valid_i && in_ready_o;
  assign adv_o       = prod_full_q && (!res_full_q || out_ready_i);
  assign out_valid_o = res_full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_full_q <= 1'b0;
      res_full_q  <= 1'b0;
    end else begin
      if (load_o)     prod_full_q <= 1'b1;
      else if (adv_o) prod_full_q <= 1'b0;

      if (adv_o)            res_full_q <= 1'b1;
      else if (out_ready_i) res_full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mac52_simd.sv
module mac52_simd #(
  parameter int unsigned LANES  = mac52_pkg::LANES_D,
  parameter int unsigned LANE_W = mac52_pkg::LANE_W_D,
  parameter int unsigned MUL_W  = mac52_pkg::MUL_W_D,
  localparam int unsigned VEC_W = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic             half_i,
  input  logic [VEC_W-1:0] acc_i,
  input  logic [VEC_W-1:0] mul_a_i,
  input  logic [VEC_W-1:0] mul_b_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [VEC_W-1:0] out_data_o
);
  logic load, adv;

  mac52_pipe_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .load_o      (load),
    .adv_o       (adv)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    mac52_lane #(
      .LANE_W (LANE_W),
      .MUL_W  (MUL_W)
    ) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load),
      .adv_i   (adv),
      .half_i  (half_i),
      .acc_i   (acc_i  [j*LANE_W +: LANE_W]),
      .mul_a_i (mul_a_i[j*LANE_W +: LANE_W]),
      .mul_b_i (mul_b_i[j*LANE_W +: LANE_W]),
      .res_o   (out_data_o[j*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/mac52_simd_chk.sv
module mac52_simd_chk #(
  parameter int unsigned VEC_W = 512
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [VEC_W-1:0] out_data_o
);
  // R7: a stalled result neither drops nor changes
  a_r7_hold_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> out_valid_o);
  a_r7_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> $stable(out_data_o));

  // R8: backpressure only when the result slot is stuck
  a_r8_ready_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_valid_o || out_ready_i) |-> in_ready_o);
  a_r8_ready_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  // R6: an accepted operation has a result present two cycles later
  a_r6_result_due: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |-> ##2 out_valid_o);

  // R9: idle outputs while held in reset
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r9_reset_idle: assert (!out_valid_o && in_ready_o);
    end
  end
endmodule

bind mac52_simd mac52_simd_chk #(.VEC_W(VEC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o)
);

// File: tb/sim_mac52_simd.sv
module sim_mac52_simd;
  localparam int CLK_P = 10;
  localparam int VW    = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, half = 1'b0, out_ready = 1'b0;
  logic [VW-1:0] acc = '0, ma = '0, mb = '0;
  logic          in_ready, out_valid;
  logic [VW-1:0] out_data;

  int n_chk = 0, n_bad = 0, cyc = 0, dir_idx = 0;
  bit pend = 0, prev_stall = 0, done = 0;
  logic [VW-1:0] prev_data;

  logic [VW-1:0] exp_q[$];
  int            cyc_q[$];
  string         tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  mac52_simd u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .half_i(half), .acc_i(acc), .mul_a_i(ma), .mul_b_i(mb),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data)
  );

  function automatic logic [VW-1:0] ref_mac(logic [VW-1:0] a_v, logic [VW-1:0] x, logic [VW-1:0] y, logic h);
    logic [VW-1:0] r;
    logic [103:0]  p;
    logic [51:0]   s;
    for (int l = 0; l < 8; l++) begin
      p = {52'd0, x[l*64 +: 52]} * {52'd0, y[l*64 +: 52]};
      s = h ? p[103:52] : p[51:0];
      r[l*64 +: 64] = a_v[l*64 +: 64] + {12'd0, s};
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd_vec(int kind);
    logic [VW-1:0] v;
    for (int w = 0; w < 16; w++) v[w*32 +: 32] = $urandom;
    for (int l = 0; l < 8; l++) begin
      if (kind == 1 && $urandom_range(0, 3) == 0) v[l*64 +: 52] = '1;
      if (kind == 2 && $urandom_range(0, 1) == 0) v[l*64 +: 64] = 64'hFFFF_FFFF_FFFF_F000 | 64'($urandom_range(0, 4095));
    end
    return v;
  endfunction

  function automatic void check(bit ok, string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endfunction

  task automatic next_op();
    string t;
    if (dir_idx < 5) begin
      case (dir_idx)
        0: begin acc = '1; ma = {8{64'h000F_FFFF_FFFF_FFFF}}; mb = ma; half = 1'b0; t = "R5"; end
        1: begin acc = '0; ma = {8{64'h000F_FFFF_FFFF_FFFF}}; mb = ma; half = 1'b1; t = "R4"; end
        2: begin acc = rnd_vec(0); ma = rnd_vec(0) | {8{64'hFFF0_0000_0000_0000}};
                 mb = rnd_vec(0) | {8{64'hFFF0_0000_0000_0000}}; half = 1'b0; t = "R2"; end
        3: begin acc = {4{64'd0, 64'hFFFF_FFFF_FFFF_FFFF}}; ma = {4{64'd0, 64'd1}}; mb = ma; half = 1'b0; t = "R1"; end
        default: begin acc = '0; ma = {8{64'd3}}; mb = {8{64'd5}}; half = 1'b0; t = "R3"; end
      endcase
      dir_idx++;
    end else begin
      acc  = rnd_vec(2);
      ma   = rnd_vec(1);
      mb   = rnd_vec(1);
      half = 1'($urandom_range(0, 1));
      t    = half ? "R4" : "R3";
    end
    tag_q.push_back(t);
  endtask

  task automatic step(input bit want_v, input bit rdy, input bit free_flow);
    logic [VW-1:0] e;
    @(negedge clk);
    cyc++;
    if (!pend && want_v) begin next_op(); pend = 1; end
    in_valid  = pend;
    out_ready = rdy;
    #1;
    if (prev_stall) begin
      check(out_valid == 1'b1, "R7 valid held", {511'd0, out_valid}, {511'd0, 1'b1});
      check(out_data === prev_data, "R7 data held", out_data, prev_data);
    end
    check(in_ready == !(out_valid && !out_ready), "R8 in_ready", {511'd0, in_ready}, {511'd0, !(out_valid && !out_ready)});
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected result", out_data, '0);
      end else begin
        e = exp_q.pop_front();
        check(out_data === e, tag_q.pop_front(), out_data, e);
        if (free_flow) check(cyc - cyc_q[0] == 2, "R6 latency", VW'(cyc - cyc_q[0]), VW'(2));
        void'(cyc_q.pop_front());
      end
    end
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
    if (in_valid && in_ready) begin
      exp_q.push_back(ref_mac(acc, ma, mb, half));
      cyc_q.push_back(cyc);
      pend = 0;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && in_ready, "R9 in reset", {510'd0, out_valid, in_ready}, {510'd0, 2'b01});
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!out_valid && in_ready, "R9 after reset", {510'd0, out_valid, in_ready}, {510'd0, 2'b01});
    // free flow: directed then random, exact latency
    for (int i = 0; i < 60; i++) step(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1);
    // random valid and ready
    for (int i = 0; i < 3000; i++) step($urandom_range(0, 1) == 1, $urandom_range(0, 2) != 0, 1'b0);
    // heavy stall
    for (int i = 0; i < 1500; i++) step(1'b1, $urandom_range(0, 4) == 0, 1'b0);
    for (int i = 0; i < 50 && (pend || exp_q.size() != 0); i++) step(1'b0, 1'b1, 1'b0);
    check(exp_q.size() == 0 && !pend, "R6 all results drained", VW'(exp_q.size()), '0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule